// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls one parallel I/O port of `WIDTH` pins. A small register bus exposes five locations. The first is an output data register. The second is a read-only view of the synchronised pin levels. The third is a direction register. The last two are per-pin pull-enable and reduced-drive registers. Each pin feeds a pad model through four signals: an output value, an output enable, a pull enable and a drive-strength select.

An on-chip peripheral can claim individual pins through an ownership vector. It then supplies the output value and the output enable for those pins. The port's direction bit no longer affects driving on a claimed pin. It still decides what a read of the data location returns for that bit. Pull devices are forced off on any pin that is being driven. The reduced-drive select reaches the pad only on driven pins. Software may write any register at any moment, and a stored setting takes effect once the pin's mode allows it.

Top module: `gpio_port`

## Requirements
- R1: Reset clears the data, direction, pull and reduced-drive registers. After reset every pin is undriven (`pad_oe_o` = 0) and `pad_pull_o` and `pad_rdrv_o` are 0.
- R2: A write to address 0 (data) is stored. On a pin with no peripheral owner, `pad_out_o` shows the stored bit from the cycle after the write. A data read returns the stored bit for pins whose direction bit (address 2) is 1.
- R3: A data read (address 0) returns the synchronised pin level for bits whose direction bit is 0.
- R4: A read of address 1 (input) always returns the synchronised pin level, whatever the direction and ownership.
- R5: A change on `pin_i` first shows in read data after the second rising clock edge following the change, and not after the first.
- R6: For a pin whose `periph_own_i` bit is 1, `pad_oe_o` and `pad_out_o` equal `periph_oe_i` and `periph_out_i`, and the direction bit has no effect on them.
- R7: While a peripheral owns a pin, the direction bit still picks the source of that bit in a data read.
- R8: `pad_pull_o` is the pull-enable bit (address 3) masked by the inverse of `pad_oe_o`, so no pin is pulled while it is driven.
- R9: `pad_rdrv_o` is the reduced-drive bit (address 4) masked by `pad_oe_o`.
- R10: Writes to address 1 change no register. Reads of addresses 5 to 7 return zero.
- R11: Settings written while they cannot act are still stored and can be read back. They act once the pin's mode changes: a data write during peripheral ownership reaches the pad when ownership ends, and a pull setting reaches the pad when the pin stops driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for `addr_i`, combinational |
| periph_own_i | input | WIDTH | Per-pin peripheral ownership |
| periph_out_i | input | WIDTH | Peripheral output value |
| periph_oe_i | input | WIDTH | Peripheral output enable |
| pin_i | input | WIDTH | Pin levels from the pad, asynchronous |
| pad_out_o | output | WIDTH | Output value to the pad |
| pad_oe_o | output | WIDTH | Output enable to the pad |
| pad_pull_o | output | WIDTH | Pull device enable to the pad |
| pad_rdrv_o | output | WIDTH | Reduced drive select to the pad |

## Verification
A wrong register bit is seen in the same cycle, either as a wrong read-back or as a wrong pad output, once the pin's mode lets that register act. An error in the ownership multiplexer shows only on the pins whose owner bit is set. The bench therefore mixes owned and unowned pins within a single vector. A synchroniser of the wrong depth makes read data change one edge early or one edge late, so pin changes are checked edge by edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA  = 3'd0,
    ADDR_INPUT = 3'd1,
    ADDR_DIR   = 3'd2,
    ADDR_PULL  = 3'd3,
    ADDR_RDRV  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pull_o,
  output logic [WIDTH-1:0]  rdrv_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] data_q, dir_q, pull_q, rdrv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      rdrv_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_DATA: data_q <= wdata_i;
        ADDR_DIR:  dir_q  <= wdata_i;
        ADDR_PULL: pull_q <= wdata_i;
        ADDR_RDRV: rdrv_q <= wdata_i;
        default: ;  // input register and holes are not writable
      endcase
    end
  end

  // direction bit picks the data read source, independent of ownership
  always_comb begin
    case (addr_i)
      ADDR_DATA:  rdata_o = (data_q & dir_q) | (pin_sync_i & ~dir_q);
      ADDR_INPUT: rdata_o = pin_sync_i;
      ADDR_DIR:   rdata_o = dir_q;
      ADDR_PULL:  rdata_o = pull_q;
      ADDR_RDRV:  rdata_o = rdrv_q;
      default:    rdata_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign pull_o = pull_q;
  assign rdrv_o = rdrv_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pull_i,
  input  logic [WIDTH-1:0] rdrv_i,
  input  logic [WIDTH-1:0] own_i,
  input  logic [WIDTH-1:0] p_out_i,
  input  logic [WIDTH-1:0] p_oe_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] pull_o,
  output logic [WIDTH-1:0] rdrv_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic drv;
    assign drv       = own_i[b] ? p_oe_i[b] : dir_i[b];
    assign out_o[b]  = own_i[b] ? p_out_i[b] : data_i[b];
    assign oe_o[b]   = drv;
    assign pull_o[b] = pull_i[b] & ~drv;
    assign rdrv_o[b] = rdrv_i[b] & drv;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  periph_own_i,
  input  logic [WIDTH-1:0]  periph_out_i,
  input  logic [WIDTH-1:0]  periph_oe_i,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_pull_o,
  output logic [WIDTH-1:0]  pad_rdrv_o
);
  logic [WIDTH-1:0] pin_sync, data_q, dir_q, pull_q, rdrv_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_cfg_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .data_o    (data_q),
    .dir_o     (dir_q),
    .pull_o    (pull_q),
    .rdrv_o    (rdrv_q),
    .rdata_o   (rdata_o)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) i_pad (
    .data_i (data_q),
    .dir_i  (dir_q),
    .pull_i (pull_q),
    .rdrv_i (rdrv_q),
    .own_i  (periph_own_i),
    .p_out_i(periph_out_i),
    .p_oe_i (periph_oe_i),
    .out_o  (pad_out_o),
    .oe_o   (pad_oe_o),
    .pull_o (pad_pull_o),
    .rdrv_o (pad_rdrv_o)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  periph_own_i,
  input logic [WIDTH-1:0]  periph_oe_i,
  input logic [WIDTH-1:0]  pin_i,
  input logic [WIDTH-1:0]  pad_out_o,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [WIDTH-1:0]  pad_pull_o,
  input logic [WIDTH-1:0]  pad_rdrv_o
);
  // edges since reset, saturating; pin history valid after two
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r6_periph_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ periph_oe_i) & periph_own_i) == '0);

  a_r8_no_pull_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pull_o & pad_oe_o) == '0);

  a_r9_rdrv_driven_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_rdrv_o & ~pad_oe_o) == '0);

  a_r10_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(ADDR_RDRV)) |-> rdata_o == '0);

  a_r2_data_to_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(ADDR_DATA)) |=>
      ((pad_out_o ^ $past(wdata_i)) & ~periph_own_i) == '0);

  a_r5_input_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && addr_i == ADDR_W'(ADDR_INPUT)) |-> rdata_o == $past(pin_i, 2));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .periph_own_i(periph_own_i),
  .periph_oe_i (periph_oe_i),
  .pin_i       (pin_i),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .pad_pull_o  (pad_pull_o),
  .pad_rdrv_o  (pad_rdrv_o)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int W = 8;
  localparam int CYC = 20;
  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_PULL = 3, K_RDRV = 4;

  typedef struct {
    int         kind;
    logic [W-1:0] val;
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic we = 1'b0;
  logic [W-1:0] wdata = '0, own = '0, p_out = '0, p_oe = '0, pin = '0;
  logic [W-1:0] rdata, pad_out, pad_oe, pad_pull, pad_rdrv;

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CYC/2) clk = ~clk;

  gpio_port #(.WIDTH(W)) i_gpio_port (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .periph_own_i(own), .periph_out_i(p_out), .periph_oe_i(p_oe),
    .pin_i(pin), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pull_o(pad_pull),
    .pad_rdrv_o(pad_rdrv)
  );

  // monitor: compare queued expectations half a cycle after they were set up
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      exp_t e;
      logic [W-1:0] act;
      e = q.pop_front();
      case (e.kind)
        K_RD:    act = rdata;
        K_OUT:   act = pad_out;
        K_OE:    act = pad_oe;
        K_PULL:  act = pad_pull;
        default: act = pad_rdrv;
      endcase
      n_vec++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.val);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; we = 1'b1; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  // queue one expectation; it is compared before the next edge
  task automatic chk(input int kind, input logic [2:0] a, input logic [W-1:0] v,
                     input string req);
    exp_t e;
    addr = a;
    e.kind = kind; e.val = v; e.req = req;
    q.push_back(e);
    step(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CYC * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    pin = 8'hA5;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    step(1);
    // R1: reset state
    chk(K_RD, 3'd2, 8'h00, "R1 dir");
    chk(K_RD, 3'd3, 8'h00, "R1 pull");
    chk(K_RD, 3'd4, 8'h00, "R1 rdrv");
    chk(K_OE, 3'd0, 8'h00, "R1 oe");
    chk(K_PULL, 3'd0, 8'h00, "R1 pull pad");
    chk(K_RDRV, 3'd0, 8'h00, "R1 rdrv pad");
    step(2);
    chk(K_RD, 3'd1, 8'hA5, "R4 input");
    chk(K_RD, 3'd0, 8'hA5, "R3 data all inputs");
    // R2: data write, mixed direction
    wr(3'd0, 8'h3C);
    wr(3'd2, 8'hF0);
    chk(K_RD, 3'd0, 8'h35, "R2 R3 mixed read");
    chk(K_OUT, 3'd0, 8'h3C, "R2 pad out");
    chk(K_OE, 3'd0, 8'hF0, "R2 pad oe");
    // R10: input address not writable, holes read zero
    wr(3'd1, 8'hFF);
    chk(K_RD, 3'd1, 8'hA5, "R10 input unchanged");
    chk(K_RD, 3'd0, 8'h35, "R10 data unchanged");
    chk(K_RD, 3'd2, 8'hF0, "R10 dir unchanged");
    chk(K_RD, 3'd3, 8'h00, "R10 pull unchanged");
    chk(K_RD, 3'd4, 8'h00, "R10 rdrv unchanged");
    chk(K_RD, 3'd5, 8'h00, "R10 hole 5");
    chk(K_RD, 3'd7, 8'h00, "R10 hole 7");
    // R5: two-edge latency
    pin = 8'h5A;
    chk(K_RD, 3'd1, 8'hA5, "R5 no edge");
    chk(K_RD, 3'd1, 8'hA5, "R5 one edge");
    chk(K_RD, 3'd1, 8'h5A, "R5 two edges");
    chk(K_RD, 3'd0, 8'h3A, "R3 data after pin change");
    // R8, R9, R11: pull and drive gating
    wr(3'd3, 8'hFF);
    chk(K_PULL, 3'd0, 8'h0F, "R8 pull on inputs only");
    chk(K_RD, 3'd3, 8'hFF, "R11 pull stored");
    wr(3'd4, 8'hFF);
    chk(K_RDRV, 3'd0, 8'hF0, "R9 rdrv on outputs only");
    // R6, R7: peripheral owns low nibble
    own = 8'h0F; p_oe = 8'h03; p_out = 8'h0E;
    chk(K_OE, 3'd0, 8'hF3, "R6 oe mix");
    chk(K_OUT, 3'd0, 8'h3E, "R6 out mix");
    chk(K_PULL, 3'd0, 8'h0C, "R8 pull with periph");
    chk(K_RDRV, 3'd0, 8'hF3, "R9 rdrv with periph");
    chk(K_RD, 3'd0, 8'h3A, "R7 read source by dir");
    // R6: peripheral owns all, direction ignored
    own = 8'hFF;
    chk(K_OE, 3'd0, 8'h03, "R6 dir ignored");
    chk(K_OUT, 3'd0, 8'h0E, "R6 periph out");
    chk(K_RD, 3'd0, 8'h3A, "R7 all owned read");
    chk(K_RD, 3'd1, 8'h5A, "R4 input while owned");
    // R11: data write while owned takes effect on release
    wr(3'd0, 8'hC3);
    chk(K_OUT, 3'd0, 8'h0E, "R11 write hidden while owned");
    chk(K_RD, 3'd0, 8'hCA, "R11 R7 stored data read");
    own = 8'h00;
    chk(K_OUT, 3'd0, 8'hC3, "R11 write visible on release");
    chk(K_OE, 3'd0, 8'hF0, "R11 dir back in control");
    // R11: pull acts once pins stop driving
    wr(3'd2, 8'h00);
    chk(K_PULL, 3'd0, 8'hFF, "R11 R8 pull after dir clear");
    chk(K_RDRV, 3'd0, 8'h00, "R9 rdrv off undriven");
    chk(K_RD, 3'd0, 8'h5A, "R3 all inputs again");
    @(negedge clk);
    #1;
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule